// File: doc/BRIEF.md
# Programmable-Frequency DDS Sine Generator

This block synthesises a sine wave for an 8-bit DAC by direct digital synthesis. The system clock is fixed and well above the highest tone it produces. Each enabled cycle, a wide phase accumulator adds a phase increment. Only the top bits of the accumulator address a built-in sine table, so the output frequency is fout = fclk * increment / 2^ACC_W. With the default 32-bit accumulator at 50 MHz, one increment step is about 0.012 Hz. A narrow increment would be far too coarse for a 100 Hz to 1 MHz range: an 8-bit increment on an 8-bit accumulator steps by about 195 kHz.

The increment comes from one of two sources. The first is a direct input port for linear tuning. The second is a table of twelve preset increments spaced geometrically between a low and a high frequency; a one-cycle step pulse walks through it. The table is computed at elaboration. A new increment is registered and used from the next accumulation, with no phase reset, so every frequency change is phase-continuous. The signed sine sample has its top bit inverted, which gives offset binary for the DAC. A parameter selects whether the table stores a full wave or a mirrored quarter wave.

Top module: `dds_sine_gen`

## Requirements
- R1: While reset is held and in the cycle after it is released, `phase_o` is 0 and `sample_o` is 8'h80.
- R2: With `use_preset` = 0, the `inc_in` value sampled at one clock edge is added to the accumulator at the next enabled edge, modulo 2^ACC_W. The phase is not reset when the increment changes.
- R3: While `en` is low, `phase_o` holds its value.
- R4: With `use_preset` = 1, the increment is preset entry i, where i is the current step index. Entry i = round(F_LO * (F_HI/F_LO)^(i/(N_PRESET-1)) * 2^ACC_W / CLK_HZ).
- R5: The step index is 0 after reset. Each clock with `step_i` high advances it by one, and after index N_PRESET-1 (11 by default) it wraps to 0.
- R6: For an accumulator value whose top 8 bits are k, the sample is the two's-complement value round(127*sin(2*pi*k/256)) with bit 7 inverted. It appears on `sample_o` two clock edges after that value appears on `phase_o`.
- R7: With a constant increment that divides 2^ACC_W, the output repeats every 2^ACC_W / increment cycles; an increment of 2^26 gives 64 cycles.
- R8: The quarter-wave table variant produces exactly the same output sequence as the full-wave variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance the accumulator when high; hold it when low |
| use_preset | input | 1 | 0 selects `inc_in`; 1 selects the preset table |
| inc_in | input | ACC_W | Direct phase increment |
| step_i | input | 1 | One-cycle pulse that advances the preset index |
| phase_o | output | ACC_W | Phase accumulator value |
| sample_o | output | SMP_W | Offset-binary sine sample for the DAC |

## Verification
An increment presented at one edge moves `phase_o` at the following enabled edge. A step pulse changes the preset increment one edge later, so the phase moves by the new preset one edge after that. The sample belonging to a phase value is due two edges after that value shows on `phase_o`. The bench drives inputs on the falling edge. A cycle model in the bench is updated on the rising edge with the same register counts, and the ports are compared with it on the falling edge, so every comparison waits for the stated latency. The directed checks on hold, wrap and period compare values taken a known number of falling edges apart.

// File: rtl/dds_pkg.sv
package dds_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // signed sine code for table index k of 2**aw entries, amplitude 2**(dw-1)-1
   function automatic int sine_code(input int k, input int aw, input int dw);
      real ang;
      real amp;
      ang = TWO_PI * real'(k) / real'(2 ** aw);
      amp = real'((2 ** (dw - 1)) - 1);
      return int'(amp * $sin(ang));
   endfunction

   // geometric preset increment for entry i of n
   function automatic longint preset_inc(input int i, input int n, input int acc_w,
                                         input longint clk_hz, input longint f_lo,
                                         input longint f_hi);
      real ratio;
      real f;
      ratio = real'(f_hi) / real'(f_lo);
      f     = real'(f_lo) * (ratio ** (real'(i) / real'(n - 1)));
      return longint'(f * (2.0 ** acc_w) / real'(clk_hz));
   endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             use_preset,
   input  logic [ACC_W-1:0] inc_dir,
   input  logic [ACC_W-1:0] inc_pre,
   output logic [ACC_W-1:0] acc_o
);
   logic [ACC_W-1:0] inc_q;
   logic [ACC_W-1:0] acc_q;

   // increment is registered first, then used: a change never resets phase
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inc_q <= '0;
         acc_q <= '0;
      end else begin
         inc_q <= use_preset ? inc_pre : inc_dir;
         if (en) acc_q <= acc_q + inc_q;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/dds_step_sel.sv
module dds_step_sel #(
   parameter int     ACC_W    = 32,
   parameter int     N_PRESET = 12,
   parameter longint CLK_HZ   = 50_000_000,
   parameter longint F_LO     = 100,
   parameter longint F_HI     = 1_000_000,
   localparam int    IDX_W    = $clog2(N_PRESET)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [ACC_W-1:0] inc_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PRESET - 1);

   logic [ACC_W-1:0] tbl [N_PRESET];
   logic [IDX_W-1:0] idx_q;

   for (genvar i = 0; i < N_PRESET; i++) begin : g_tbl
      localparam longint VAL = dds_pkg::preset_inc(i, N_PRESET, ACC_W, CLK_HZ, F_LO, F_HI);
      assign tbl[i] = VAL[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   assign idx_o = idx_q;
   assign inc_o = tbl[idx_q];
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
   parameter int PHASE_W      = 8,
   parameter int SMP_W        = 8,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase_i,
   output logic [SMP_W-1:0]   sample_o
);
   localparam int FULL_N = 2 ** PHASE_W;
   localparam int QTR_N  = 2 ** (PHASE_W - 2);

   logic [PHASE_W-1:0]      addr_q;
   logic signed [SMP_W-1:0] val;
   logic [SMP_W-1:0]        smp_q;

   if (QUARTER_WAVE) begin : g_quarter
      logic [SMP_W-1:0]   mag [QTR_N + 1];
      logic [1:0]         quad;
      logic [PHASE_W-2:0] lin_idx;
      logic [PHASE_W-2:0] mir_idx;

      for (genvar k = 0; k <= QTR_N; k++) begin : g_ent
         localparam int CODE = dds_pkg::sine_code(k, PHASE_W, SMP_W);
         assign mag[k] = SMP_W'(CODE);
      end

      assign quad    = addr_q[PHASE_W-1:PHASE_W-2];
      assign lin_idx = {1'b0, addr_q[PHASE_W-3:0]};
      // second and fourth quadrants read the table backwards
      assign mir_idx = quad[0] ? ((PHASE_W-1)'(QTR_N) - lin_idx) : lin_idx;

      always_comb begin
         val = signed'(mag[mir_idx]);
         if (quad[1]) val = -val;
      end
   end else begin : g_full
      logic [SMP_W-1:0] wave [FULL_N];

      for (genvar k = 0; k < FULL_N; k++) begin : g_ent
         localparam int CODE = dds_pkg::sine_code(k, PHASE_W, SMP_W);
         assign wave[k] = SMP_W'(CODE);
      end

      assign val = signed'(wave[addr_q]);
   end

   // address register, then sample register with top bit inverted to offset binary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         smp_q  <= {1'b1, {(SMP_W-1){1'b0}}};
      end else begin
         addr_q <= phase_i;
         smp_q  <= {~val[SMP_W-1], val[SMP_W-2:0]};
      end
   end

   assign sample_o = smp_q;
endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
   parameter int     ACC_W        = 32,
   parameter int     PHASE_W      = 8,
   parameter int     SMP_W        = 8,
   parameter int     N_PRESET     = 12,
   parameter bit     QUARTER_WAVE = 1'b1,
   parameter longint CLK_HZ       = 50_000_000,
   parameter longint F_LO         = 100,
   parameter longint F_HI         = 1_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             use_preset,
   input  logic [ACC_W-1:0] inc_in,
   input  logic             step_i,
   output logic [ACC_W-1:0] phase_o,
   output logic [SMP_W-1:0] sample_o
);
   localparam int IDX_W = $clog2(N_PRESET);

   if (PHASE_W < 4 || PHASE_W > 12) begin : g_bad_phase
      $error("PHASE_W must lie in 4..12");
   end
   if (ACC_W < PHASE_W || ACC_W > 48) begin : g_bad_acc
      $error("ACC_W must be at least PHASE_W and at most 48");
   end
   if (SMP_W < 4) begin : g_bad_smp
      $error("SMP_W must be at least 4");
   end
   if (N_PRESET < 2) begin : g_bad_preset
      $error("N_PRESET must be at least 2");
   end
   if (F_LO <= 0 || F_HI < F_LO || 2 * F_HI > CLK_HZ) begin : g_bad_freq
      $error("frequency range must be positive and below half the clock");
   end

   logic [IDX_W-1:0] step_idx;
   logic [ACC_W-1:0] inc_pre;
   logic [ACC_W-1:0] acc;

   dds_step_sel #(
      .ACC_W(ACC_W), .N_PRESET(N_PRESET), .CLK_HZ(CLK_HZ), .F_LO(F_LO), .F_HI(F_HI)
   ) sel_i (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .idx_o(step_idx), .inc_o(inc_pre)
   );

   dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
      .clk(clk), .rst_n(rst_n), .en(en), .use_preset(use_preset),
      .inc_dir(inc_in), .inc_pre(inc_pre), .acc_o(acc)
   );

   dds_sine_rom #(.PHASE_W(PHASE_W), .SMP_W(SMP_W), .QUARTER_WAVE(QUARTER_WAVE)) rom_i (
      .clk(clk), .rst_n(rst_n), .phase_i(acc[ACC_W-1:ACC_W-PHASE_W]), .sample_o(sample_o)
   );

   assign phase_o = acc;
endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
   parameter int ACC_W    = 32,
   parameter int SMP_W    = 8,
   parameter int N_PRESET = 12,
   parameter int IDX_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             use_preset,
   input logic [ACC_W-1:0] inc_in,
   input logic             step_i,
   input logic [ACC_W-1:0] phase_o,
   input logic [SMP_W-1:0] sample_o,
   input logic [IDX_W-1:0] step_idx
);
   localparam logic [SMP_W-1:0] MID = {1'b1, {(SMP_W-1){1'b0}}};

   // cycles since reset release, saturating; gates lookbacks
   logic [1:0] live;
   always_ff @(posedge clk) begin
      if (!rst_n)           live <= '0;
      else if (live != 2'd3) live <= live + 2'd1;
   end

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(phase_o));

   // R2
   direct_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd3 && en && $past(!use_preset)) |=> phase_o == $past(phase_o) + $past(inc_in, 2));

   // R5
   step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && step_idx == IDX_W'(N_PRESET - 1)) |=> step_idx == '0);

   // R6
   upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd3 && !$past(phase_o[ACC_W-1], 2)) |-> sample_o[SMP_W-1]);

   // R6
   lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd3 && $past(phase_o[ACC_W-1], 2)) |-> sample_o <= MID);
endmodule

bind dds_sine_gen dds_sine_gen_chk #(
   .ACC_W(ACC_W), .SMP_W(SMP_W), .N_PRESET(N_PRESET), .IDX_W($clog2(N_PRESET))
) chk_i (
   .clk(clk), .rst_n(rst_n), .en(en), .use_preset(use_preset), .inc_in(inc_in),
   .step_i(step_i), .phase_o(phase_o), .sample_o(sample_o), .step_idx(step_idx)
);

// File: tb/dds_sine_gen_tb_top.sv
module dds_sine_gen_tb_top;
   localparam int ACC_W = 32;
   localparam int NP    = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              use_preset = 1'b0;
   logic [ACC_W-1:0]  inc_in = '0;
   logic              step_i = 1'b0;
   logic [ACC_W-1:0]  phase_o, phase_f;
   logic [7:0]        sample_o, sample_f;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   bit model_on = 0;

   always #4 clk = ~clk;

   dds_sine_gen dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .use_preset(use_preset), .inc_in(inc_in),
      .step_i(step_i), .phase_o(phase_o), .sample_o(sample_o)
   );

   dds_sine_gen #(.QUARTER_WAVE(1'b0)) dut_f (
      .clk(clk), .rst_n(rst_n), .en(en), .use_preset(use_preset), .inc_in(inc_in),
      .step_i(step_i), .phase_o(phase_f), .sample_o(sample_f)
   );

   function automatic logic [7:0] exp_sample(input int k);
      int v;
      v = int'(127.0 * $sin(6.283185307179586 * real'(k) / 256.0));
      return {~v[7], v[6:0]};
   endfunction

   function automatic logic [ACC_W-1:0] exp_preset(input int i);
      real f;
      longint r;
      f = 100.0 * ((1_000_000.0 / 100.0) ** (real'(i) / real'(NP - 1)));
      r = longint'(f * (2.0 ** ACC_W) / 50_000_000.0);
      return r[ACC_W-1:0];
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle model of the requirements
   logic [ACC_W-1:0] m_inc, m_acc;
   logic [7:0]       m_ph, m_smp;
   int               m_sel;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_inc <= '0; m_acc <= '0; m_sel <= 0; m_ph <= '0; m_smp <= 8'h80;
      end else begin
         m_inc <= use_preset ? exp_preset(m_sel) : inc_in;
         if (step_i) m_sel <= (m_sel == NP - 1) ? 0 : m_sel + 1;
         if (en) m_acc <= m_acc + m_inc;
         m_ph  <= m_acc[ACC_W-1:ACC_W-8];
         m_smp <= exp_sample(int'(m_ph));
      end
   end

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         check(phase_o == m_acc, use_preset ? "R4 preset phase" : "R2 direct phase", phase_o, m_acc);
         check(sample_o == m_smp, "R6 sample", sample_o, m_smp);
         check(sample_f == sample_o, "R8 quarter vs full", sample_o, sample_f);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [ACC_W-1:0] a0, a1;
      int t_prev, t_now, cnt;
      bit prev7;
      void'($urandom(32'd20240611));
      cyc(4);
      // R1: during reset
      check(phase_o == '0 && sample_o == 8'h80, "R1 in reset", {phase_o, sample_o}, 40'h80);
      rst_n = 1'b1;
      cyc(1);
      check(phase_o == '0 && sample_o == 8'h80, "R1 after release", {phase_o, sample_o}, 40'h80);
      model_on = 1;

      // R7: period with increment 2^26
      inc_in = 32'h0400_0000; en = 1'b1;
      cyc(10);
      t_prev = -1; cnt = 0; prev7 = sample_o[7];
      for (int c = 0; c < 200; c++) begin
         cyc(1);
         if (sample_o[7] && !prev7) begin
            if (t_prev >= 0 && cnt < 2) begin
               check(c - t_prev == 64, "R7 period", c - t_prev, 64);
               cnt++;
            end
            t_prev = c;
         end
         prev7 = sample_o[7];
      end

      // R3: hold while idle
      en = 1'b0;
      cyc(2); a0 = phase_o; cyc(10);
      check(phase_o == a0, "R3 hold", phase_o, a0);
      en = 1'b1;

      // R2: boundary increments, phase-continuous change
      inc_in = '1; cyc(5);
      inc_in = 32'h0000_0001; cyc(1); a0 = phase_o; cyc(1); a1 = phase_o;
      check(a1 - a0 == 32'h1, "R2 new increment continuous", a1 - a0, 1);
      inc_in = 32'h8000_0000; cyc(6);

      // R4 and R5: walk presets
      use_preset = 1'b1;
      for (int i = 0; i < NP; i++) begin
         cyc(3); a0 = phase_o; cyc(1); a1 = phase_o;
         check(a1 - a0 == exp_preset(i), "R4 preset step", a1 - a0, exp_preset(i));
         step_i = 1'b1; cyc(1); step_i = 1'b0;
      end
      cyc(3); a0 = phase_o; cyc(1); a1 = phase_o;
      check(a1 - a0 == exp_preset(0), "R5 wrap to first preset", a1 - a0, exp_preset(0));

      // random mix
      for (int c = 0; c < 4000; c++) begin
         en         = ($urandom_range(0, 7) != 0);
         use_preset = ($urandom_range(0, 3) == 0);
         step_i     = ($urandom_range(0, 15) == 0);
         if ($urandom_range(0, 9) == 0) inc_in = $urandom;
         cyc(1);
      end
      step_i = 1'b0;
      cyc(4);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule